// File: doc/BRIEF.md
# Dual-Clock Parity-Checked Memory Block

This block is a 256-word by 9-bit embedded memory with two ports. The write port runs on its own clock, and so does the read port. A port acts on a clock edge only when both of its active-low qualifiers are low: the block select and the strobe. The top bit of each word can hold a parity bit. Both ports check that bit against a selectable odd or even sense, and each port raises its own error flag.

The read path has two timings, chosen by a mode input that is captured while reset is held. In transparent timing, the word is on the output right after the edge that samples the read. In pipelined timing, an extra output register holds the word back by one more read-clock edge. When a read and a write hit the same address on the same edge, the write data goes to the output instead of the old memory contents. That result is only defined when both ports share one clock.

Top module: `dual_clock_parity_ram`

## Requirements
- R1: The memory stores a word at a write-clock edge only when wrSelN and wrStrobeN are both low at that edge. If either is high, the stored contents are left unchanged.
- R2: A read happens at a read-clock edge only when rdSelN and rdStrobeN are both low. With no read, rdData and rdParErr keep their last values.
- R3: Transparent timing (mode latched as 0): the word at rdAddr is on rdData after the same read-clock edge that samples the read.
- R4: Pipelined timing (mode latched as 1): the word reaches rdData only after the second read-clock edge that follows the start of the read. Reads issued back to back come out in order, one per cycle.
- R5: Parity sense: with oddSense = 1, a 9-bit word is correct when it has an odd number of ones. With oddSense = 0, it is correct when it has an even number. The same rule applies on both ports.
- R6: wrParErr goes high in the write-clock cycle after an enabled write whose 9-bit word has the wrong parity. It drops again after one cycle if the next write is correct or there is no write. The word is still stored unchanged.
- R7: rdParErr flags a word on rdData that has the wrong parity. It changes at the same edge as the data it describes, in both timings.
- R8: When a read and a write are both enabled on the same edge at the same address, rdData takes the write data. This holds only when both ports run on one common clock.
- R9: A low rstN, sampled on the clock edges, clears rdData, rdParErr and wrParErr to zero and captures pipeMode. Changes to pipeMode after reset have no effect until the next reset.
- R10: wrParErr stays low after an edge with no enabled write, even if wrData has the wrong parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous reset, active low, sampled on both clocks |
| pipeMode | input | 1 | Read timing selection, captured while reset is held: 1 = pipelined, 0 = transparent |
| oddSense | input | 1 | Parity sense: 1 = odd, 0 = even |
| wrSelN | input | 1 | Write block select, active low |
| wrStrobeN | input | 1 | Write strobe, active low |
| wrAddr | input | 8 | Write address |
| wrData | input | 9 | Write data; bit 8 can carry parity |
| rdSelN | input | 1 | Read block select, active low |
| rdStrobeN | input | 1 | Read strobe, active low |
| rdAddr | input | 8 | Read address |
| rdData | output | 9 | Read data |
| rdParErr | output | 1 | Parity error on the word in rdData |
| wrParErr | output | 1 | Parity error on the last enabled write |

## Verification
The bench builds the block with its default 8-bit address and 9-bit word and drives both clock pins from one clock. Every location is written once, so the full address range holds known words before the corner cases run. The common clock is what makes same-edge forwarding observable and deterministic. The bench applies two resets with different mode values, so the same parity and hold scenarios run under both read timings.

// File: rtl/dcpr_pkg.sv
package dcpr_pkg;

  // Decoded strobes from the control side to the datapath
  typedef struct packed {
    logic wrEn;    // write qualified this edge
    logic rdEn;    // read qualified this edge
    logic fwdHit;  // read and write collide on one address
    logic pipeOn;  // latched read timing: 1 = extra output register
  } ramStrobes_t;

endpackage

// File: rtl/dcpr_ctrl.sv
module dcpr_ctrl
  import dcpr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              wrSelN,
  input  logic              wrStrobeN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdSelN,
  input  logic              rdStrobeN,
  input  logic [ADDR_W-1:0] rdAddr,
  output ramStrobes_t       stb
);

  logic pipeLatched;

  // Read timing is captured only while reset is held
  always_ff @(posedge rdClk) begin
    if (!rstN) pipeLatched <= pipeMode;
  end

  logic wrQual, rdQual;
  assign wrQual = !wrSelN && !wrStrobeN;
  assign rdQual = !rdSelN && !rdStrobeN;

  always_comb begin
    stb.wrEn   = wrQual;
    stb.rdEn   = rdQual;
    stb.fwdHit = wrQual && rdQual && (wrAddr == rdAddr);
    stb.pipeOn = pipeLatched;
  end

endmodule

// File: rtl/dcpr_datapath.sv
module dcpr_datapath
  import dcpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ramStrobes_t       stb,
  input  logic              oddSense,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic              wrParErr
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Write side
  always_ff @(posedge wrClk) begin
    if (stb.wrEn) mem[wrAddr] <= wrData;
  end

  logic wrBad;
  assign wrBad = (^wrData) != oddSense;

  always_ff @(posedge wrClk) begin
    if (!rstN) wrParErr <= 1'b0;
    else       wrParErr <= stb.wrEn && wrBad;
  end

  // Read side: first stage is the array output register
  logic [DATA_W-1:0] rdWord;
  logic              rdWordBad;
  assign rdWord    = stb.fwdHit ? wrData : mem[rdAddr];
  assign rdWordBad = (^rdWord) != oddSense;

  logic [DATA_W-1:0] stage1Data, stage2Data;
  logic              stage1Err, stage2Err, stage1Vld;

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      stage1Data <= '0;
      stage1Err  <= 1'b0;
      stage1Vld  <= 1'b0;
      stage2Data <= '0;
      stage2Err  <= 1'b0;
    end else begin
      stage1Vld <= stb.rdEn;
      if (stb.rdEn) begin
        stage1Data <= rdWord;
        stage1Err  <= rdWordBad;
      end
      if (stage1Vld) begin
        stage2Data <= stage1Data;
        stage2Err  <= stage1Err;
      end
    end
  end

  assign rdData   = stb.pipeOn ? stage2Data : stage1Data;
  assign rdParErr = stb.pipeOn ? stage2Err  : stage1Err;

endmodule

// File: rtl/dual_clock_parity_ram.sv
module dual_clock_parity_ram
  import dcpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              oddSense,
  input  logic              wrSelN,
  input  logic              wrStrobeN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSelN,
  input  logic              rdStrobeN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic              wrParErr
);

  ramStrobes_t stb;
  logic        modePipe;

  dcpr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .rdClk(rdClk), .rstN(rstN), .pipeMode(pipeMode),
    .wrSelN(wrSelN), .wrStrobeN(wrStrobeN), .wrAddr(wrAddr),
    .rdSelN(rdSelN), .rdStrobeN(rdStrobeN), .rdAddr(rdAddr),
    .stb(stb)
  );

  dcpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .oddSense(oddSense), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdParErr(rdParErr),
    .wrParErr(wrParErr)
  );

  assign modePipe = stb.pipeOn;

endmodule

// File: rtl/dcpr_checker.sv
module dcpr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              pipeOn,
  input logic              oddSense,
  input logic              wrSelN,
  input logic              wrStrobeN,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdSelN,
  input logic              rdStrobeN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdParErr,
  input logic              wrParErr
);

  // R10: the write flag needs an enabled write on the edge before
  a_r10_wrerr_needs_write: assert property (@(posedge wrClk) disable iff (!rstN)
    wrParErr |-> $past(!wrSelN && !wrStrobeN));

  // R6: the write flag only follows a word of wrong parity
  a_r6_wrerr_bad_word: assert property (@(posedge wrClk) disable iff (!rstN)
    wrParErr |-> ($past(^wrData) != $past(oddSense)));

  // R2: in transparent timing, output and flag hold when no read is issued
  a_r2_hold_idle: assert property (@(posedge rdClk) disable iff (!rstN)
    (!pipeOn && (rdSelN || rdStrobeN)) |=> ($stable(rdData) && $stable(rdParErr)));

  // R8: same-address collision forwards write data (common clock)
  a_r8_forward: assert property (@(posedge rdClk) disable iff (!rstN)
    (!pipeOn && !rdSelN && !rdStrobeN && !wrSelN && !wrStrobeN && (wrAddr == rdAddr))
    |=> (rdData == $past(wrData)));

endmodule

bind dual_clock_parity_ram dcpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .pipeOn(modePipe),
  .oddSense(oddSense), .wrSelN(wrSelN), .wrStrobeN(wrStrobeN),
  .wrAddr(wrAddr), .wrData(wrData), .rdSelN(rdSelN), .rdStrobeN(rdStrobeN),
  .rdAddr(rdAddr), .rdData(rdData), .rdParErr(rdParErr), .wrParErr(wrParErr)
);

// File: tb/dual_clock_parity_ram_tb.sv
module dual_clock_parity_ram_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pipeMode = 1'b0;
  logic       oddSense = 1'b1;
  logic       wrSelN = 1'b1, wrStrobeN = 1'b1;
  logic [7:0] wrAddr = '0;
  logic [8:0] wrData = '0;
  logic       rdSelN = 1'b1, rdStrobeN = 1'b1;
  logic [7:0] rdAddr = '0;
  logic [8:0] rdData;
  logic       rdParErr, wrParErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clock_parity_ram dut_i (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .oddSense(oddSense), .wrSelN(wrSelN), .wrStrobeN(wrStrobeN),
    .wrAddr(wrAddr), .wrData(wrData), .rdSelN(rdSelN), .rdStrobeN(rdStrobeN),
    .rdAddr(rdAddr), .rdData(rdData), .rdParErr(rdParErr), .wrParErr(wrParErr)
  );

  int    total = 0;
  int    bad = 0;
  bit    compareOn = 0;
  string curReq = "R9";

  // Behavioural reference: array plus a queue of words in flight
  logic [8:0] mMem [256];
  logic [8:0] mOutData = '0;
  logic       mOutErr = 0;
  logic       mWrErr = 0;
  bit         mPipe = 0;
  logic [9:0] pendQ [$];   // {err, data} waiting for the second edge

  always @(posedge clk) begin
    bit wEn, rEn;
    logic [8:0] w;
    if (!rstN) begin
      mOutData = '0; mOutErr = 0; mWrErr = 0;
      mPipe = pipeMode;
      pendQ.delete();
    end else begin
      wEn = !wrSelN && !wrStrobeN;
      rEn = !rdSelN && !rdStrobeN;
      mWrErr = wEn && ((^wrData) != oddSense);
      if (mPipe && pendQ.size() > 0) begin
        {mOutErr, mOutData} = pendQ.pop_front();
      end
      if (rEn) begin
        w = (wEn && wrAddr == rdAddr) ? wrData : mMem[rdAddr];
        if (mPipe) pendQ.push_back({((^w) != oddSense), w});
        else begin mOutData = w; mOutErr = (^w) != oddSense; end
      end
      if (wEn) mMem[wrAddr] = wrData;
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      total++;
      if (rdData !== mOutData || rdParErr !== mOutErr || wrParErr !== mWrErr) begin
        bad++;
        $display("FAIL %s model: actual data=%h rerr=%b werr=%b expected data=%h rerr=%b werr=%b",
                 curReq, rdData, rdParErr, wrParErr, mOutData, mOutErr, mWrErr);
      end
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ws, input logic wst, input logic [7:0] wa,
                      input logic [8:0] wd, input logic rs, input logic rst_,
                      input logic [7:0] ra);
    wrSelN = ws; wrStrobeN = wst; wrAddr = wa; wrData = wd;
    rdSelN = rs; rdStrobeN = rst_; rdAddr = ra;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(1, 1, 8'd0, 9'd0, 1, 1, 8'd0);
  endtask

  function automatic logic [8:0] goodWord(input logic [7:0] a);
    return {~^a, a};   // odd number of ones
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    // Phase A: transparent timing
    rstN = 0; pipeMode = 0; oddSense = 1;
    idle(); idle(); idle();
    compareOn = 1;
    curReq = "R9";
    chk("R9 reset data", rdData, 9'h000);
    chk("R9 reset flags", {7'd0, rdParErr, wrParErr}, 9'h000);
    rstN = 1;
    curReq = "R1";
    for (int i = 0; i < 256; i++) step(0, 0, i[7:0], goodWord(i[7:0]), 1, 1, 8'd0);
    chk("R6 good words no flag", {8'd0, wrParErr}, 9'h000);

    curReq = "R3";
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd5);
    chk("R3 transparent read", rdData, goodWord(8'd5));
    chk("R7 good word no flag", {8'd0, rdParErr}, 9'h000);

    curReq = "R2";
    step(1, 1, 8'd0, 9'd0, 1, 0, 8'd6);
    chk("R2 select high holds", rdData, goodWord(8'd5));
    step(1, 1, 8'd0, 9'd0, 0, 1, 8'd6);
    chk("R2 strobe high holds", rdData, goodWord(8'd5));

    curReq = "R1";
    step(0, 1, 8'd7, 9'h0AA, 1, 1, 8'd0);
    step(1, 0, 8'd7, 9'h0AA, 1, 1, 8'd0);
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd7);
    chk("R1 unqualified writes ignored", rdData, goodWord(8'd7));

    curReq = "R6";
    step(0, 0, 8'd9, 9'h009, 1, 1, 8'd0);
    chk("R6 write flag raised", {8'd0, wrParErr}, 9'h001);
    idle();
    chk("R6 write flag one cycle", {8'd0, wrParErr}, 9'h000);
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd9);
    chk("R6 bad word stored", rdData, 9'h009);
    chk("R7 read flag on bad word", {8'd0, rdParErr}, 9'h001);

    curReq = "R10";
    step(1, 0, 8'd3, 9'h009, 1, 1, 8'd0);
    chk("R10 select high no flag", {8'd0, wrParErr}, 9'h000);
    step(0, 1, 8'd3, 9'h009, 1, 1, 8'd0);
    chk("R10 strobe high no flag", {8'd0, wrParErr}, 9'h000);

    curReq = "R5";
    oddSense = 0;
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd9);
    chk("R5 even sense accepts even word", {8'd0, rdParErr}, 9'h000);
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd5);
    chk("R5 even sense rejects odd word", {8'd0, rdParErr}, 9'h001);
    step(0, 0, 8'd40, goodWord(8'd40), 1, 1, 8'd0);
    chk("R5 even sense write flag", {8'd0, wrParErr}, 9'h001);
    oddSense = 1;

    curReq = "R8";
    step(0, 0, 8'd20, 9'h155, 0, 0, 8'd20);
    chk("R8 forwarded write data", rdData, 9'h155);
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd20);
    chk("R8 collision word stored", rdData, 9'h155);

    curReq = "R9";
    pipeMode = 1;
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd5);
    chk("R9 mode change ignored", rdData, goodWord(8'd5));

    // Phase B: pipelined timing
    rstN = 0;
    idle(); idle();
    chk("R9 second reset data", rdData, 9'h000);
    chk("R9 second reset flags", {7'd0, rdParErr, wrParErr}, 9'h000);
    rstN = 1;

    curReq = "R4";
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd5);
    chk("R4 not yet after first edge", rdData, 9'h000);
    idle();
    chk("R4 valid after second edge", rdData, goodWord(8'd5));
    curReq = "R2";
    idle();
    chk("R2 pipelined hold", rdData, goodWord(8'd5));

    curReq = "R7";
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd9);
    chk("R7 flag not early", {8'd0, rdParErr}, 9'h000);
    idle();
    chk("R7 pipelined bad data", rdData, 9'h009);
    chk("R7 pipelined flag aligned", {8'd0, rdParErr}, 9'h001);

    curReq = "R4";
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd1);
    step(1, 1, 8'd0, 9'd0, 0, 0, 8'd2);
    chk("R4 back to back first", rdData, goodWord(8'd1));
    idle();
    chk("R4 back to back second", rdData, goodWord(8'd2));

    curReq = "R8";
    step(0, 0, 8'd30, 9'h0F3, 0, 0, 8'd30);
    idle();
    chk("R8 pipelined forward", rdData, 9'h0F3);

    idle();
    summary();
    $finish;
  end

endmodule